// File: doc/BRIEF.md
# Multiplexed Parallel-Port Write Sequencer

This block runs one 8-bit write to external memory over a 16-bit multiplexed address/data bus. Every phase is counted in core clock cycles. A write is requested through a valid/ready handshake that carries a 16-bit address, a data byte and a settings word. The settings word holds a 5-bit data-cycle duration, a hold-cycle enable, a flash-mode enable and the address-latch polarity. The block first places the full address on the bus and pulses the address latch enable (ALE). Next it drives the upper address byte on the high lane and the data byte on the low lane, and pulls the active-low write strobe low. It then optionally keeps both lanes for one hold cycle and, in flash mode, adds a recovery gap. It reports busy while a write is in progress and pulses done when the write completes.

The settings are captured when a request is accepted, so software may change them freely while a write runs. Requests are taken only while the block is idle. A new request can be accepted in the same cycle that done is high, so writes can run back to back.

Top module: `pp_write_seq`

## Requirements
- R1: While idle, `pp_wr_n` and `pp_rd_n` are 1, `pp_ad_oe` is 0, `pp_ad_o` is 0, `req_ready` is 1, `busy` is 0, and `pp_ale` sits at its inactive level, which equals `cfg_ale_low`.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle until the write ends, `busy` is 1 and `req_ready` is 0.
- R3: In the first two cycles after acceptance, ALE is active, `pp_ad_oe` is 1 and `pp_ad_o` carries the full 16-bit address.
- R4: In the first cycle after ALE goes inactive, `pp_ad_o` still carries the full address. In the second cycle it carries {address[15:8], data}. `pp_wr_n` falls in the cycle after that.
- R5: `pp_wr_n` stays low for W = max(D − F, 1) cycles. D is `cfg_dur` (0 to 31, where 0 behaves like 1) and F is 7 when `cfg_flash` is 1 and 0 otherwise.
- R6: For the W strobe cycles and the one cycle before them, `pp_ad_o` holds {address[15:8], data} with `pp_ad_oe` at 1. The byte is therefore stable for W+1 cycles before the strobe rises.
- R7: When `cfg_hold` is 1, the lanes stay driven with the same value for one cycle after `pp_wr_n` rises. When it is 0, no such cycle occurs.
- R8: In flash mode, after the strobe (and the hold cycle, if any) the bus is released for 3 cycles before the write ends. From one strobe rising edge to the next falling edge there are then at least F+H+1 cycles, where H is 1 when `cfg_hold` is 1 and 0 otherwise.
- R9: `done` is 1 for exactly one cycle: the first idle cycle after a write. A request presented in that cycle is accepted.
- R10: With `cfg_ale_low` = 1, ALE is 0 during its two active cycles and 1 at all other times. Out of reset, with `cfg_ale_low` = 0, ALE is active high and idles at 0.
- R11: The settings are sampled at acceptance. Changing `cfg_dur`, `cfg_hold`, `cfg_flash` or `cfg_ale_low` during a write does not alter that write's timing or ALE levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | 16 | Write address |
| req_data | input | 8 | Write data byte |
| cfg_dur | input | 5 | Data-cycle duration D in clocks |
| cfg_hold | input | 1 | Add one hold cycle after the strobe |
| cfg_flash | input | 1 | Flash mode: strobe shortened by 7, recovery gap added |
| cfg_ale_low | input | 1 | 1 selects an active-low ALE |
| pp_ale | output | 1 | Address latch enable |
| pp_wr_n | output | 1 | Write strobe, active low |
| pp_rd_n | output | 1 | Read strobe, held inactive high |
| pp_ad_o | output | 16 | Multiplexed address/data out |
| pp_ad_oe | output | 1 | Bus output enable |
| busy | output | 1 | Write in progress |
| done | output | 1 | One-cycle pulse when a write ends |

## Verification
A behavioural model predicts every output for every cycle, and the bench compares the design with it on each clock.

- **Duration values.** Writes use durations 5, 1, 0 and 31 to separate the normal strobe width from the lower clamp and the field maximum.
- **Flash mode.** Flash writes with duration 10 and 3 show that seven cycles are subtracted, that the result is clamped at one cycle, and that the recovery gap appears.
- **Hold cycle.** Writes with and without the hold cycle show whether the lanes are kept for one extra cycle.
- **Polarity and streaming.** An active-low ALE run and a back-to-back burst cover the polarity inversion and acceptance during the done cycle.
- **Mid-write changes.** Settings scrambled right after acceptance check that the captured settings, not the live ones, govern the write.

// File: rtl/ppw_pkg.sv
package ppw_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_ALE    = 3'd1,
        PH_SETUP  = 3'd2,
        PH_STROBE = 3'd3,
        PH_HOLD   = 3'd4,
        PH_GAP    = 3'd5
    } ppw_phase_e;

endpackage

// File: rtl/ppw_len_calc.sv
// Strobe length minus one: max(D - F, 1) - 1, with F the flash reduction.
module ppw_len_calc #(
    parameter int DUR_W       = 5,
    parameter int CNT_W       = 5,
    parameter int FLASH_EXTRA = 7
) (
    input  logic [DUR_W-1:0] dur,
    input  logic             flash,
    output logic [CNT_W-1:0] strobe_m1
);
    localparam int RED = FLASH_EXTRA;

    int unsigned d_i;
    int unsigned w_i;

    always_comb begin
        d_i = int'(dur);
        if (flash) begin
            w_i = (d_i > RED) ? (d_i - RED) : 1;
        end else begin
            w_i = (d_i > 0) ? d_i : 1;
        end
        strobe_m1 = CNT_W'(w_i - 1);
    end
endmodule

// File: rtl/ppw_phase_ctr.sv
// Down-counter shared by all phases: load starts a phase, zero ends it.
module ppw_phase_ctr #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt  = cnt_q;
    assign zero = (cnt_q == '0);
endmodule

// File: rtl/pp_write_seq.sv
module pp_write_seq
    import ppw_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int DUR_W       = 5,
    parameter int FLASH_EXTRA = 7,
    parameter int ALE_LEN     = 2,
    parameter int SETUP_LEN   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [DUR_W-1:0]  cfg_dur,
    input  logic              cfg_hold,
    input  logic              cfg_flash,
    input  logic              cfg_ale_low,
    output logic              pp_ale,
    output logic              pp_wr_n,
    output logic              pp_rd_n,
    output logic [ADDR_W-1:0] pp_ad_o,
    output logic              pp_ad_oe,
    output logic              busy,
    output logic              done
);
    localparam int CNT_W     = DUR_W;
    localparam int HI_W      = ADDR_W - DATA_W;
    // Recovery so that strobe-rise to next strobe-fall spans F+H+1 cycles:
    // the next write already spends idle + ALE + setup cycles before its strobe.
    localparam int PRE_STB   = 1 + ALE_LEN + SETUP_LEN;
    localparam int FLASH_GAP = (FLASH_EXTRA + 1 > PRE_STB) ? (FLASH_EXTRA + 1 - PRE_STB) : 0;

    typedef struct packed {
        ppw_phase_e        ph;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [DUR_W-1:0]  dur;
        logic              hold;
        logic              flash;
        logic              pol;
        logic              done;
    } regs_t;

    localparam regs_t REGS_RST = '{ph: PH_IDLE, default: '0};

    regs_t            r_d, r_q;
    logic             ctr_load;
    logic [CNT_W-1:0] ctr_val;
    logic [CNT_W-1:0] ctr_cnt;
    logic             ctr_zero;
    logic [CNT_W-1:0] strobe_m1;
    logic [ADDR_W-1:0] lanes;

    ppw_len_calc #(
        .DUR_W       (DUR_W),
        .CNT_W       (CNT_W),
        .FLASH_EXTRA (FLASH_EXTRA)
    ) u_len (
        .dur       (r_q.dur),
        .flash     (r_q.flash),
        .strobe_m1 (strobe_m1)
    );

    ppw_phase_ctr #(
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_val (ctr_val),
        .cnt      (ctr_cnt),
        .zero     (ctr_zero)
    );

    // Next-state process
    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        ctr_load = 1'b0;
        ctr_val  = '0;
        unique case (r_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    r_d.addr  = req_addr;
                    r_d.data  = req_data;
                    r_d.dur   = cfg_dur;
                    r_d.hold  = cfg_hold;
                    r_d.flash = cfg_flash;
                    r_d.pol   = cfg_ale_low;
                    r_d.ph    = PH_ALE;
                    ctr_load  = 1'b1;
                    ctr_val   = CNT_W'(ALE_LEN - 1);
                end
            end
            PH_ALE: begin
                if (ctr_zero) begin
                    r_d.ph   = PH_SETUP;
                    ctr_load = 1'b1;
                    ctr_val  = CNT_W'(SETUP_LEN - 1);
                end
            end
            PH_SETUP: begin
                if (ctr_zero) begin
                    r_d.ph   = PH_STROBE;
                    ctr_load = 1'b1;
                    ctr_val  = strobe_m1;
                end
            end
            PH_STROBE: begin
                if (ctr_zero) begin
                    ctr_load = 1'b1;
                    if (r_q.hold) begin
                        r_d.ph  = PH_HOLD;
                        ctr_val = '0;
                    end else if (r_q.flash && FLASH_GAP > 0) begin
                        r_d.ph  = PH_GAP;
                        ctr_val = CNT_W'(FLASH_GAP - 1);
                    end else begin
                        r_d.ph   = PH_IDLE;
                        r_d.done = 1'b1;
                    end
                end
            end
            PH_HOLD: begin
                if (ctr_zero) begin
                    ctr_load = 1'b1;
                    if (r_q.flash && FLASH_GAP > 0) begin
                        r_d.ph  = PH_GAP;
                        ctr_val = CNT_W'(FLASH_GAP - 1);
                    end else begin
                        r_d.ph   = PH_IDLE;
                        r_d.done = 1'b1;
                    end
                end
            end
            PH_GAP: begin
                if (ctr_zero) begin
                    r_d.ph   = PH_IDLE;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.ph = PH_IDLE;
        endcase
    end

    // Register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    // Pin decode from the registered phase
    assign lanes = {r_q.addr[ADDR_W-1 -: HI_W], r_q.data};

    always_comb begin
        pp_ad_o  = '0;
        pp_ad_oe = 1'b0;
        unique case (r_q.ph)
            PH_ALE: begin
                pp_ad_o  = r_q.addr;
                pp_ad_oe = 1'b1;
            end
            PH_SETUP: begin
                pp_ad_o  = (ctr_cnt == CNT_W'(SETUP_LEN - 1)) ? r_q.addr : lanes;
                pp_ad_oe = 1'b1;
            end
            PH_STROBE, PH_HOLD: begin
                pp_ad_o  = lanes;
                pp_ad_oe = 1'b1;
            end
            default: ;
        endcase
    end

    assign pp_ale    = (r_q.ph == PH_IDLE) ? cfg_ale_low : ((r_q.ph == PH_ALE) ^ r_q.pol);
    assign pp_wr_n   = (r_q.ph != PH_STROBE);
    assign pp_rd_n   = 1'b1;
    assign busy      = (r_q.ph != PH_IDLE);
    assign req_ready = (r_q.ph == PH_IDLE);
    assign done      = r_q.done;

    // Assertions
    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (busy && !req_ready));

    assert_ale_two_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.ph == PH_ALE) |=> (r_q.ph == PH_ALE));

    assert_wr_after_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pp_wr_n) |-> ($past(r_q.ph) == PH_SETUP));

    assert_byte_setup_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pp_wr_n) |-> ($stable(pp_ad_o) && pp_ad_oe));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(r_q.dur) && $stable(r_q.hold) &&
                                   $stable(r_q.flash) && $stable(r_q.pol)));
endmodule

// File: tb/pp_write_seq_tb.sv
module pp_write_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_data = '0;
    logic [4:0]  cfg_dur = '0;
    logic        cfg_hold = 1'b0;
    logic        cfg_flash = 1'b0;
    logic        cfg_ale_low = 1'b0;
    logic        pp_ale, pp_wr_n, pp_rd_n, pp_ad_oe, busy, done;
    logic [15:0] pp_ad_o;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    string ctx = "reset";

    always #4 clk = ~clk;   // 125 MHz

    pp_write_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .cfg_dur(cfg_dur),
        .cfg_hold(cfg_hold), .cfg_flash(cfg_flash), .cfg_ale_low(cfg_ale_low),
        .pp_ale(pp_ale), .pp_wr_n(pp_wr_n), .pp_rd_n(pp_rd_n), .pp_ad_o(pp_ad_o),
        .pp_ad_oe(pp_ad_oe), .busy(busy), .done(done)
    );

    // Behavioural reference: m_t counts cycles since acceptance, 0 = idle.
    int          m_t = 0, m_w = 1, m_h = 0, m_g = 0, m_total = 0;
    bit          m_done = 0, m_pol = 0;
    logic [15:0] m_addr = '0;
    logic [7:0]  m_data = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_t = 0;
            m_done = 0;
        end else if (m_t == 0) begin
            m_done = 0;
            if (req_valid) begin
                int d, f;
                m_addr = req_addr;
                m_data = req_data;
                m_pol  = cfg_ale_low;
                d = int'(cfg_dur);
                f = cfg_flash ? 7 : 0;
                m_w = (d - f < 1) ? 1 : d - f;
                m_h = cfg_hold ? 1 : 0;
                m_g = cfg_flash ? 3 : 0;
                m_total = 4 + m_w + m_h + m_g;
                m_t = 1;
            end
        end else if (m_t == m_total) begin
            m_t = 0;
            m_done = 1;
        end else begin
            m_t = m_t + 1;
        end
    end

    // Compare every output on every falling edge
    always @(negedge clk) begin
        logic        e_ale, e_wr_n, e_oe, e_busy;
        logic [15:0] e_ad;
        string       tag;
        e_busy = (m_t != 0);
        e_ale  = (m_t == 0) ? cfg_ale_low : ((m_t <= 2) ^ m_pol);   // R10
        e_wr_n = !(m_t >= 5 && m_t <= 4 + m_w);
        e_oe   = (m_t >= 1 && m_t <= 4 + m_w + m_h);
        if (m_t >= 1 && m_t <= 3)                 e_ad = m_addr;
        else if (m_t >= 4 && m_t <= 4 + m_w + m_h) e_ad = {m_addr[15:8], m_data};
        else                                     e_ad = '0;
        if (m_t == 0)                  tag = m_done ? "R9" : "R1";
        else if (m_t <= 2)             tag = "R3";
        else if (m_t <= 4)             tag = "R4";
        else if (m_t <= 4 + m_w)       tag = "R5/R6";
        else if (m_t <= 4 + m_w + m_h) tag = "R7";
        else                           tag = "R8";
        tests++;
        if (pp_ale !== e_ale || pp_wr_n !== e_wr_n || pp_rd_n !== 1'b1 ||
            pp_ad_oe !== e_oe || pp_ad_o !== e_ad || busy !== e_busy ||
            req_ready !== !e_busy || done !== m_done) begin
            fails++;
            $display("FAIL %s (R2 handshake) [%s] t=%0d: got ale=%b wr_n=%b rd_n=%b oe=%b ad=%h busy=%b rdy=%b done=%b, exp ale=%b wr_n=%b rd_n=1 oe=%b ad=%h busy=%b rdy=%b done=%b",
                     tag, ctx, m_t, pp_ale, pp_wr_n, pp_rd_n, pp_ad_oe, pp_ad_o, busy,
                     req_ready, done, e_ale, e_wr_n, e_oe, e_ad, e_busy, !e_busy, m_done);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: got %0d cycles, exp completion", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic do_write(input logic [15:0] a, input logic [7:0] d, input logic [4:0] dur,
                            input bit h, input bit f, input bit p, input bit scramble);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_addr = a; req_data = d; cfg_dur = dur;
        cfg_hold = h; cfg_flash = f; cfg_ale_low = p;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (scramble) begin   // R11: settings altered after acceptance
            cfg_dur = ~dur; cfg_hold = ~h; cfg_flash = ~f; cfg_ale_low = ~p;
            req_addr = ~a; req_data = ~d;
        end
    endtask

    task automatic settle();
        @(negedge clk);
        while (m_t != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);           // R1 and R10 reset state checked each cycle
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        ctx = "basic D=5";        do_write(16'h1234, 8'hA5, 5'd5,  0, 0, 0, 0); settle();
        ctx = "D=1";              do_write(16'hBEEF, 8'h3C, 5'd1,  0, 0, 0, 0); settle();
        ctx = "D=0 clamp R5";     do_write(16'h0F0F, 8'h81, 5'd0,  0, 0, 0, 0); settle();
        ctx = "hold R7";          do_write(16'hC001, 8'h7E, 5'd4,  1, 0, 0, 0); settle();
        ctx = "flash D=10 R8";    do_write(16'h5A5A, 8'h11, 5'd10, 1, 1, 0, 0); settle();
        ctx = "flash clamp R5";   do_write(16'hA0A0, 8'h22, 5'd3,  0, 1, 0, 0); settle();
        ctx = "D=31";             do_write(16'hFFFF, 8'hFF, 5'd31, 0, 0, 0, 0); settle();
        ctx = "active-low R10";   do_write(16'h2468, 8'h99, 5'd2,  1, 0, 1, 0); settle();
        ctx = "back-to-back R9";
        do_write(16'h1111, 8'h01, 5'd3, 0, 0, 0, 0);
        do_write(16'h2222, 8'h02, 5'd9, 1, 1, 0, 0);
        do_write(16'h3333, 8'h03, 5'd2, 0, 0, 1, 0);
        settle();
        ctx = "mid-write change R11"; do_write(16'h7788, 8'h5D, 5'd6, 0, 0, 0, 1); settle();
        ctx = "mid-write change flash R11"; do_write(16'h8877, 8'hD5, 5'd12, 1, 1, 1, 1); settle();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule